// File: doc/BRIEF.md
# UART FIFO DMA Request Controller

This block sits between a UART's transmit and receive FIFOs and a DMA engine. It watches the occupancy of both FIFOs and compares each against its own programmable trigger level. For each direction it raises two kinds of transfer request. A burst request follows the trigger threshold. A single request follows whether at least one entry can be moved. The receive and transmit thresholds face in opposite directions: receive asks for service once enough data has arrived, and transmit asks once enough room has opened up.

A small register port holds the per-channel DMA enables, a stop-on-error control and the interrupt masks. Through the same port software reads the raw and masked status, clears status bits, and writes transmit characters. A receive error can latch a halt on receive DMA that lasts until software clears the error status. Completion pulses from the DMA engine set per-channel done flags, and these drive a single interrupt through the masks. All requests are suppressed while the UART runs without its FIFOs.

The block has two state machines. The receive gate has the states GATE_OPEN and GATE_HALTED. It moves from GATE_OPEN to GATE_HALTED when a receive error arrives with stop-on-error set. It moves back when software clears the error status in a cycle with no new error. Each status flag is a two-state machine, EVT_IDLE and EVT_PEND. A flag moves from EVT_IDLE to EVT_PEND on its set event. It returns to EVT_IDLE on a clear that arrives without a set in the same cycle.

Top module: `uart_dma_req`

## Requirements
- R1: With FIFO mode on and receive DMA enabled (CTRL bit 0) and the receive gate open, `rx_burst` is high exactly when `rx_lvl >= rx_trig`.
- R2: With FIFO mode on and transmit DMA enabled (CTRL bit 1), `tx_burst` is high exactly when `tx_lvl <= tx_trig`.
- R3: Under the same enables, `rx_single` is high exactly when `rx_lvl >= 1`, and `tx_single` is high exactly when `tx_lvl <= DEPTH-1`.
- R4: Clearing CTRL bit 0 forces both receive requests low. Clearing CTRL bit 1 forces both transmit requests low. Each bit leaves the other channel untouched.
- R5: While `fifo_en` is low, all four request outputs stay low whatever the levels and enables.
- R6: When CTRL bit 2 (stop on error) is set, an `rx_err` pulse halts both receive requests. STAT bit 3 reads 1 while halted. Writing 1 to CLEAR bit 2 reopens the gate. With CTRL bit 2 clear, `rx_err` has no effect on the requests.
- R7: A `tx_done` pulse sets STAT bit 0, an `rx_done` pulse sets STAT bit 1, and an `rx_err` pulse sets STAT bit 2. Writing 1 to CLEAR (address 4) at a bit clears that bit. A set and a clear of the same bit in the same cycle leave the bit at 1.
- R8: `irq` equals (STAT[0] AND MASK[0]) OR (STAT[1] AND MASK[1]). MSTAT (address 3) reads those two ANDed bits. STAT (address 2) reads the raw bits whatever the mask holds.
- R9: A write to TXDATA (address 5) pulses `tx_push` in that same cycle and presents only `reg_wdata[7:0]` on `tx_push_data`. A write to any other address leaves `tx_push` low.
- R10: The request outputs are registered. They take their new value at the first rising edge after a change in FIFO level.
- R11: After reset, all requests, `irq` and `tx_push` are low, and CTRL (address 0), MASK (address 1) and STAT all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | UART FIFO mode enable |
| rx_lvl | input | LVL_W | Receive FIFO occupancy, 0 to DEPTH |
| tx_lvl | input | LVL_W | Transmit FIFO occupancy, 0 to DEPTH |
| rx_trig | input | TRIG_W | Receive trigger level |
| tx_trig | input | TRIG_W | Transmit trigger level |
| rx_err | input | 1 | Receive error pulse |
| rx_done | input | 1 | Receive DMA completion pulse |
| tx_done | input | 1 | Transmit DMA completion pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 CTRL, 1 MASK, 2 STAT, 3 MSTAT, 4 CLEAR, 5 TXDATA |
| reg_wdata | input | BUS_W | Register write data |
| reg_rdata | output | BUS_W | Register read data for `reg_addr` |
| rx_burst | output | 1 | Receive burst request |
| rx_single | output | 1 | Receive single request |
| tx_burst | output | 1 | Transmit burst request |
| tx_single | output | 1 | Transmit single request |
| irq | output | 1 | Masked done interrupt |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_push_data | output | 8 | Character pushed into the transmit FIFO |

## Verification
The bench builds the block with its default parameters: DEPTH 16, 4-bit trigger levels and a 32-bit register bus. At that size it can sweep all 17 occupancies against all 16 trigger values on both channels. That sweep covers both threshold edges and the empty and full ends. It also walks all eight combinations of FIFO mode and the two channel enables, and every mask pattern against every done pattern. The 32-bit bus makes it possible to show that the upper 24 bits of a transmit write are dropped.

// File: rtl/udr_pkg.sv
package udr_pkg;

    typedef enum logic [2:0] {
        ADDR_CTRL  = 3'd0,
        ADDR_MASK  = 3'd1,
        ADDR_STAT  = 3'd2,
        ADDR_MSTAT = 3'd3,
        ADDR_CLEAR = 3'd4,
        ADDR_TXD   = 3'd5
    } reg_addr_e;

    localparam int FLAG_TX_DONE = 0;
    localparam int FLAG_RX_DONE = 1;
    localparam int FLAG_RX_ERR  = 2;
    localparam int NUM_FLAGS    = 3;
    localparam int NUM_DONE     = 2;
    localparam int CTRL_W       = 3;
    localparam int BYTE_W       = 8;

    typedef struct packed {
        logic stop_on_err;
        logic tx_en;
        logic rx_en;
    } dma_ctrl_t;

    typedef enum logic {
        GATE_OPEN,
        GATE_HALTED
    } gate_state_e;

    typedef enum logic {
        EVT_IDLE,
        EVT_PEND
    } evt_state_e;

endpackage

// File: rtl/udr_evt_flag.sv
module udr_evt_flag
    import udr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);

    evt_state_e state_q;
    evt_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EVT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EVT_IDLE: if (set_evt)               state_d = EVT_PEND;
            EVT_PEND: if (clr_req && !set_evt)   state_d = EVT_IDLE;
            default:                             state_d = EVT_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == EVT_PEND);
    end

endmodule

// File: rtl/udr_err_gate.sv
module udr_err_gate
    import udr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_err,
    input  logic stop_on_err,
    input  logic err_clr,
    output logic halted
);

    gate_state_e state_q;
    gate_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN:   if (rx_err && stop_on_err) state_d = GATE_HALTED;
            GATE_HALTED: if (err_clr && !rx_err)    state_d = GATE_OPEN;
            default:                                state_d = GATE_OPEN;
        endcase
    end

    always_comb begin
        halted = (state_q == GATE_HALTED);
    end

endmodule

// File: rtl/udr_chan_req.sv
module udr_chan_req #(
    parameter int DEPTH  = 16,
    parameter bit IS_RX  = 1'b1,
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int TRIG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allow,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [TRIG_W-1:0] trig,
    output logic              burst,
    output logic              single
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [LVL_W-1:0] trig_ext;
    logic             burst_d;
    logic             single_d;

    always_comb begin
        trig_ext = {{(LVL_W - TRIG_W){1'b0}}, trig};
    end

    generate
        if (IS_RX) begin : g_rx
            always_comb begin
                burst_d  = allow && (lvl >= trig_ext);
                single_d = allow && (lvl != '0);
            end
        end else begin : g_tx
            always_comb begin
                burst_d  = allow && (lvl <= trig_ext);
                single_d = allow && (lvl < FULL_LVL);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst  <= 1'b0;
            single <= 1'b0;
        end else begin
            burst  <= burst_d;
            single <= single_d;
        end
    end

endmodule

// File: rtl/udr_regs.sv
module udr_regs
    import udr_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [BUS_W-1:0]     reg_wdata,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic                 halted,
    output dma_ctrl_t            ctrl,
    output logic [NUM_DONE-1:0]  mask,
    output logic [NUM_DONE-1:0]  masked,
    output logic [NUM_FLAGS-1:0] clr_pulse,
    output logic                 tx_push,
    output logic [BYTE_W-1:0]    tx_push_data,
    output logic [BUS_W-1:0]     reg_rdata
);

    reg_addr_e addr;

    always_comb begin
        addr = reg_addr_e'(reg_addr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
            mask <= '0;
        end else if (reg_wr) begin
            if (addr == ADDR_CTRL) ctrl <= dma_ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (addr == ADDR_MASK) mask <= reg_wdata[NUM_DONE-1:0];
        end
    end

    always_comb begin
        masked       = flags[NUM_DONE-1:0] & mask;
        clr_pulse    = (reg_wr && addr == ADDR_CLEAR) ? reg_wdata[NUM_FLAGS-1:0] : '0;
        tx_push      = reg_wr && (addr == ADDR_TXD);
        tx_push_data = reg_wdata[BYTE_W-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        case (addr)
            ADDR_CTRL:  reg_rdata[CTRL_W-1:0]      = ctrl;
            ADDR_MASK:  reg_rdata[NUM_DONE-1:0]    = mask;
            ADDR_STAT:  reg_rdata[NUM_FLAGS:0]     = {halted, flags};
            ADDR_MSTAT: reg_rdata[NUM_DONE-1:0]    = masked;
            default:    reg_rdata                  = '0;
        endcase
    end

endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
    import udr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BUS_W  = 32,
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int TRIG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [LVL_W-1:0]  rx_lvl,
    input  logic [LVL_W-1:0]  tx_lvl,
    input  logic [TRIG_W-1:0] rx_trig,
    input  logic [TRIG_W-1:0] tx_trig,
    input  logic              rx_err,
    input  logic              rx_done,
    input  logic              tx_done,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              rx_burst,
    output logic              rx_single,
    output logic              tx_burst,
    output logic              tx_single,
    output logic              irq,
    output logic              tx_push,
    output logic [7:0]        tx_push_data
);

    dma_ctrl_t            ctrl;
    logic [NUM_DONE-1:0]  mask;
    logic [NUM_DONE-1:0]  masked;
    logic [NUM_FLAGS-1:0] clr_pulse;
    logic [NUM_FLAGS-1:0] set_evt;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_DONE-1:0]  raw_done;
    logic                 gate_blocked;
    logic                 rx_allow;
    logic                 tx_allow;

    always_comb begin
        set_evt                = '0;
        set_evt[FLAG_TX_DONE]  = tx_done;
        set_evt[FLAG_RX_DONE]  = rx_done;
        set_evt[FLAG_RX_ERR]   = rx_err;
        raw_done               = flags[NUM_DONE-1:0];
        rx_allow               = fifo_en && ctrl.rx_en && !gate_blocked;
        tx_allow               = fifo_en && ctrl.tx_en;
        irq                    = |masked;
    end

    udr_regs #(.BUS_W(BUS_W)) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .flags        (flags),
        .halted       (gate_blocked),
        .ctrl         (ctrl),
        .mask         (mask),
        .masked       (masked),
        .clr_pulse    (clr_pulse),
        .tx_push      (tx_push),
        .tx_push_data (tx_push_data),
        .reg_rdata    (reg_rdata)
    );

    generate
        for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
            udr_evt_flag i_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_evt (set_evt[gi]),
                .clr_req (clr_pulse[gi]),
                .flag    (flags[gi])
            );
        end
    endgenerate

    udr_err_gate i_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_err      (rx_err),
        .stop_on_err (ctrl.stop_on_err),
        .err_clr     (clr_pulse[FLAG_RX_ERR]),
        .halted      (gate_blocked)
    );

    udr_chan_req #(.DEPTH(DEPTH), .IS_RX(1'b1)) i_rx_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .allow  (rx_allow),
        .lvl    (rx_lvl),
        .trig   (rx_trig),
        .burst  (rx_burst),
        .single (rx_single)
    );

    udr_chan_req #(.DEPTH(DEPTH), .IS_RX(1'b0)) i_tx_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .allow  (tx_allow),
        .lvl    (tx_lvl),
        .trig   (tx_trig),
        .burst  (tx_burst),
        .single (tx_single)
    );

endmodule

// File: rtl/udr_checker.sv
module udr_checker #(
    parameter int LVL_W  = 5,
    parameter int TRIG_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_en,
    input logic [LVL_W-1:0]  rx_lvl,
    input logic [LVL_W-1:0]  tx_lvl,
    input logic [TRIG_W-1:0] rx_trig,
    input logic [TRIG_W-1:0] tx_trig,
    input logic              tx_done,
    input logic              rx_burst,
    input logic              rx_single,
    input logic              tx_burst,
    input logic              tx_single,
    input logic              gate_blocked,
    input logic [1:0]        raw_done,
    input logic              irq
);

    AST_RX_BURST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_burst |-> $past(rx_lvl >= LVL_W'(rx_trig)));                          // R1

    AST_TX_BURST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_burst |-> $past(tx_lvl <= LVL_W'(tx_trig)));                          // R2

    AST_RX_SINGLE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_single |-> $past(rx_lvl != '0));                                       // R3

    AST_NO_FIFO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> !(rx_burst || rx_single || tx_burst || tx_single));         // R5

    AST_HALT_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        gate_blocked |=> !(rx_burst || rx_single));                               // R6

    AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> raw_done[0]);                                                 // R7

    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_done != 2'b00));                                             // R8

endmodule

bind uart_dma_req udr_checker #(.LVL_W(LVL_W), .TRIG_W(TRIG_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_en      (fifo_en),
    .rx_lvl       (rx_lvl),
    .tx_lvl       (tx_lvl),
    .rx_trig      (rx_trig),
    .tx_trig      (tx_trig),
    .tx_done      (tx_done),
    .rx_burst     (rx_burst),
    .rx_single    (rx_single),
    .tx_burst     (tx_burst),
    .tx_single    (tx_single),
    .gate_blocked (gate_blocked),
    .raw_done     (raw_done),
    .irq          (irq)
);

// File: tb/test_uart_dma_req.sv
`timescale 1ns/1ps
module test_uart_dma_req;

    localparam int DEPTH  = 16;
    localparam int BUS_W  = 32;
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int TRIG_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fifo_en = 1'b0;
    logic [LVL_W-1:0]  rx_lvl = '0;
    logic [LVL_W-1:0]  tx_lvl = '0;
    logic [TRIG_W-1:0] rx_trig = '0;
    logic [TRIG_W-1:0] tx_trig = '0;
    logic              rx_err = 1'b0;
    logic              rx_done = 1'b0;
    logic              tx_done = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [BUS_W-1:0]  reg_wdata = '0;
    logic [BUS_W-1:0]  reg_rdata;
    logic              rx_burst, rx_single, tx_burst, tx_single, irq, tx_push;
    logic [7:0]        tx_push_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_dma_req #(.DEPTH(DEPTH), .BUS_W(BUS_W)) i_uart_dma_req (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 req", {rx_burst, rx_single, tx_burst, tx_single, irq, tx_push}, 0);
        rd(3'd0, v); chk("R11 ctrl", v, 0);
        rd(3'd1, v); chk("R11 mask", v, 0);
        rd(3'd2, v); chk("R11 stat", v, 0);
        rst_n = 1'b1;
        settle();
        chk("R11 after release", {rx_burst, rx_single, tx_burst, tx_single}, 0);

        // R1 R3 R10 receive sweep: one edge after each level change
        fifo_en = 1'b1;
        wr(3'd0, 32'h3);
        tx_lvl = LVL_W'(DEPTH);
        for (int t = 0; t < DEPTH; t++) begin
            rx_trig = TRIG_W'(t);
            for (int l = 0; l <= DEPTH; l++) begin
                @(negedge clk);
                rx_lvl = LVL_W'(l);
                settle();
                chk("R1 R10 rx_burst", rx_burst, (l >= t));
                chk("R3 rx_single", rx_single, (l >= 1));
            end
        end

        // R2 R3 R10 transmit sweep
        for (int t = 0; t < DEPTH; t++) begin
            tx_trig = TRIG_W'(t);
            for (int l = 0; l <= DEPTH; l++) begin
                @(negedge clk);
                tx_lvl = LVL_W'(l);
                settle();
                chk("R2 R10 tx_burst", tx_burst, (l <= t));
                chk("R3 tx_single", tx_single, (l <= DEPTH - 1));
            end
        end

        // R4 R5 enable combinations
        rx_lvl = 5'd8; rx_trig = 4'd4; tx_lvl = 5'd2; tx_trig = 4'd4;
        for (int c = 0; c < 8; c++) begin
            fifo_en = c[2];
            wr(3'd0, {30'd0, c[1], c[0]});
            settle();
            chk("R4 R5 rx", {rx_burst, rx_single}, {2{c[2] & c[0]}});
            chk("R4 R5 tx", {tx_burst, tx_single}, {2{c[2] & c[1]}});
        end

        // R6 stop on error
        fifo_en = 1'b1;
        wr(3'd0, 32'h7);
        settle();
        chk("R6 pre", rx_burst, 1);
        @(negedge clk); rx_err = 1'b1;
        @(negedge clk); rx_err = 1'b0;
        settle();
        chk("R6 halted rx", {rx_burst, rx_single}, 0);
        chk("R6 tx untouched", tx_burst, 1);
        rd(3'd2, v); chk("R6 stat halt+err", v[3:2], 2'b11);
        wr(3'd0, 32'h3);
        settle();
        chk("R6 still halted", rx_burst, 0);
        wr(3'd4, 32'h4);
        settle();
        chk("R6 reopened", {rx_burst, rx_single}, 2'b11);
        rd(3'd2, v); chk("R6 stat cleared", v[3:2], 0);
        @(negedge clk); rx_err = 1'b1;
        @(negedge clk); rx_err = 1'b0;
        settle();
        chk("R6 no stop bit", rx_burst, 1);
        rd(3'd2, v); chk("R7 err flag", v[3:2], 2'b01);
        wr(3'd4, 32'h4);

        // R7 done flags, set wins
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0; rx_done = 1'b1;
        @(negedge clk); rx_done = 1'b0;
        rd(3'd2, v); chk("R7 both set", v[2:0], 3'b011);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1; tx_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tx_done = 1'b0;
        rd(3'd2, v); chk("R7 set wins", v[0], 1);
        wr(3'd4, 32'h1);
        rd(3'd2, v); chk("R7 tx cleared", v[2:0], 3'b010);
        wr(3'd4, 32'h2);
        rd(3'd2, v); chk("R7 rx cleared", v[2:0], 3'b000);

        // R8 mask against raw sweep
        for (int r = 0; r < 4; r++) begin
            for (int m = 0; m < 4; m++) begin
                wr(3'd4, 32'h3);
                @(negedge clk); tx_done = r[0]; rx_done = r[1];
                @(negedge clk); tx_done = 1'b0; rx_done = 1'b0;
                wr(3'd1, m);
                #1;
                chk("R8 irq", irq, |(r[1:0] & m[1:0]));
                rd(3'd3, v); chk("R8 mstat", v, r[1:0] & m[1:0]);
                rd(3'd2, v); chk("R8 raw", v[1:0], r[1:0]);
            end
        end

        // R9 transmit data write
        for (int k = 0; k < 4; k++) begin
            logic [31:0] d;
            d = 32'hA5C3_1E7B ^ (32'h1111_1111 * k);
            @(negedge clk);
            reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = d;
            #1;
            chk("R9 push", tx_push, 1);
            chk("R9 byte", tx_push_data, d[7:0]);
            @(negedge clk);
            reg_wr = 1'b0;
        end
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0;
        #1;
        chk("R9 no push", tx_push, 0);
        @(negedge clk);
        reg_wr = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule